// File: doc/BRIEF.md
# Program Suspend/Resume Latch Manager

This block controls the per-bitline data latches of a page buffer while a multi-level program is under way. When a suspend command arrives, it walks the page one beat of bitlines at a time. For each bitline it reduces all program data latches to a single inhibit bit and stores that bit in one fixed latch plane. The other planes are then free for a soft-bit read.

Finished cells are marked by overwriting their data with the erased pattern, which is all ones. Because of this, the inhibit state needs no storage of its own. The AND of a bitline's latches is 1 exactly when that cell is inhibited, or when its target state is the erased one.

On resume, the block takes the user data for each beat from a cache stream, ORs it with the saved inhibit bit, and rewrites every latch plane of that beat. Program data is rebuilt this way, with inhibited cells forced back to all ones.

The latch array sits outside the block. It is reached through a read port with one cycle of latency and a write port with one enable per plane.

Top module: `suspend_latch_mgr`

## Requirements
- R1: After reset, busy, rd_grant, pgm_active, done, lat_rd_en and lat_wr_en are all 0, and the block is idle.
- R2: cmd_start while idle enters the program phase, where pgm_active is 1. cmd_finish in the program phase returns the block to idle.
- R3: cmd_suspend in the program phase starts suspend processing, and busy is 1 from the next cycle until processing ends. cmd_suspend in any other phase has no effect.
- R4: During suspend, the block writes each beat's plane 0 with the bitwise AND of all NLAT planes of that beat. No other plane is written, since lat_wr_mask is 4'b0001 when NLAT is 4.
- R5: Suspend processes one beat per cycle, in column order 0 to NCOL-1. done is a one-cycle pulse in the cycle of the last write, which is NCOL+1 cycles after the command is sampled.
- R6: After suspend ends, rd_grant is 1 and busy is 0. rd_grant is 1 only in this parked phase, and no latch access is issued there.
- R7: cmd_resume while parked starts rebuild. Each cycle with cache_vld high consumes one beat of cache_data, where plane p is bits p*NB+NB-1 down to p*NB. One cycle later the block writes all planes of that column with cache_data OR the column's saved inhibit bit. Cycles with cache_vld low consume nothing.
- R8: done pulses in the cycle of the last rebuild write, and the block then returns to the program phase with busy at 0.
- R9: cmd_resume outside the parked phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Begin program phase |
| cmd_finish | input | 1 | End program phase |
| cmd_suspend | input | 1 | Request suspend |
| cmd_resume | input | 1 | Request resume |
| cache_vld | input | 1 | Cache beat valid |
| cache_data | input | NLAT*NB | Cached user data for the current beat, plane-major |
| lat_rd_en | output | 1 | Latch read request |
| lat_rd_col | output | AW | Latch read column |
| lat_rd_data | input | NLAT*NB | Latch data, one cycle after the request |
| lat_wr_en | output | 1 | Latch write strobe |
| lat_wr_col | output | AW | Latch write column |
| lat_wr_mask | output | NLAT | Per-plane write enable |
| lat_wr_data | output | NLAT*NB | Latch write data |
| busy | output | 1 | Suspend or resume processing active |
| rd_grant | output | 1 | Latches released for a read |
| pgm_active | output | 1 | Program phase |
| done | output | 1 | One-cycle pulse after the last column |

## Verification
The assertions check several rules on every cycle:
- the per-plane write mask in each mode;
- that suspend and resume commands are ignored outside their legal phases;
- that columns advance by exactly one per issued beat;
- that the parked phase issues no latch traffic.

Only the bench scenarios can show the data results. These are the AND fold across planes, planes other than 0 left untouched, the OR rebuild after the free planes were overwritten by a read, the exact done latency, and correct behaviour when the cache stream has gaps.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PGM     = 3'd1,
      ST_SUSP_GO = 3'd2,
      ST_PARKED  = 3'd3,
      ST_RES_GO  = 3'd4
   } ssr_st_e;
endpackage

// File: rtl/ssr_fold.sv
module ssr_fold #(
   parameter int NB   = 8,
   parameter int NLAT = 4
) (
   input  logic [NLAT*NB-1:0] planes,
   output logic [NB-1:0]      inh
);
   for (genvar b = 0; b < NB; b++) begin : g_bl
      logic [NLAT-1:0] stack;
      always_comb begin
         for (int p = 0; p < NLAT; p++) stack[p] = planes[p*NB + b];
      end
      assign inh[b] = &stack;
   end
endmodule

// File: rtl/ssr_merge.sv
module ssr_merge #(
   parameter int NB   = 8,
   parameter int NLAT = 4
) (
   input  logic [NLAT*NB-1:0] user,
   input  logic [NB-1:0]      inh,
   output logic [NLAT*NB-1:0] merged
);
   for (genvar p = 0; p < NLAT; p++) begin : g_pl
      assign merged[p*NB +: NB] = user[p*NB +: NB] | inh;
   end
endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
   import ssr_pkg::*;
#(
   parameter int NCOL = 16,
   parameter int AW   = 4,
   parameter int CW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_finish,
   input  logic          cmd_suspend,
   input  logic          cmd_resume,
   input  logic          cache_vld,
   output ssr_st_e       st,
   output logic          rd_en,
   output logic [AW-1:0] rd_col,
   output logic          wr_en,
   output logic [AW-1:0] wr_col,
   output logic          done
);
   logic [CW-1:0] cnt;
   logic          s1_last;
   logic          issue_left;

   assign issue_left = cnt < CW'(NCOL);
   assign rd_col     = cnt[AW-1:0];

   always_comb begin
      rd_en = 1'b0;
      if (st == ST_SUSP_GO) rd_en = issue_left;
      else if (st == ST_RES_GO) rd_en = issue_left && cache_vld;
   end

   assign done = wr_en && s1_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         wr_en   <= 1'b0;
         wr_col  <= '0;
         s1_last <= 1'b0;
      end else begin
         wr_en   <= rd_en;
         wr_col  <= rd_col;
         s1_last <= rd_en && (cnt == CW'(NCOL-1));
         if (rd_en) cnt <= cnt + 1'b1;
         unique case (st)
            ST_IDLE:    if (cmd_start) st <= ST_PGM;
            ST_PGM: begin
               if (cmd_suspend) begin
                  st  <= ST_SUSP_GO;
                  cnt <= '0;
               end else if (cmd_finish) st <= ST_IDLE;
            end
            ST_SUSP_GO: if (done) st <= ST_PARKED;
            ST_PARKED: begin
               if (cmd_resume) begin
                  st  <= ST_RES_GO;
                  cnt <= '0;
               end
            end
            ST_RES_GO:  if (done) st <= ST_PGM;
            default:    st <= ST_IDLE;
         endcase
      end
   end

   a_r3_suspend_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_suspend && (st == ST_IDLE || st == ST_PARKED || st == ST_RES_GO)) |=> (st != ST_SUSP_GO));
   a_r9_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_resume && (st == ST_IDLE || st == ST_PGM || st == ST_SUSP_GO)) |=> (st != ST_RES_GO));
   a_r5_column_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cnt != CW'(NCOL-1)) |=> (cnt == $past(cnt) + 1'b1));
   a_r6_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PARKED) |-> (!rd_en && !wr_en));
endmodule

// File: rtl/suspend_latch_mgr.sv
module suspend_latch_mgr
   import ssr_pkg::*;
#(
   parameter int NB        = 8,
   parameter int NCOL      = 16,
   parameter int NLAT      = 4,
   parameter int INH_PLANE = 0,
   localparam int AW = (NCOL > 1) ? $clog2(NCOL) : 1,
   localparam int CW = $clog2(NCOL + 1),
   localparam int DW = NLAT * NB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_start,
   input  logic          cmd_finish,
   input  logic          cmd_suspend,
   input  logic          cmd_resume,
   input  logic          cache_vld,
   input  logic [DW-1:0] cache_data,
   output logic          lat_rd_en,
   output logic [AW-1:0] lat_rd_col,
   input  logic [DW-1:0] lat_rd_data,
   output logic          lat_wr_en,
   output logic [AW-1:0] lat_wr_col,
   output logic [NLAT-1:0] lat_wr_mask,
   output logic [DW-1:0] lat_wr_data,
   output logic          busy,
   output logic          rd_grant,
   output logic          pgm_active,
   output logic          done
);
   if (NLAT < 4) begin : g_bad_nlat
      $error("NLAT must leave one inhibit plane plus three read planes");
   end
   if (INH_PLANE < 0 || INH_PLANE >= NLAT) begin : g_bad_inh
      $error("INH_PLANE out of range");
   end
   if (NB < 1 || NCOL < 1) begin : g_bad_size
      $error("NB and NCOL must be positive");
   end

   ssr_st_e       st;
   logic [NB-1:0] inh;
   logic [DW-1:0] cache_q;
   logic [DW-1:0] merged;
   logic [DW-1:0] fold_data;
   logic          rebuilding;

   ssr_seq #(.NCOL(NCOL), .AW(AW), .CW(CW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_start  (cmd_start),
      .cmd_finish (cmd_finish),
      .cmd_suspend(cmd_suspend),
      .cmd_resume (cmd_resume),
      .cache_vld  (cache_vld),
      .st         (st),
      .rd_en      (lat_rd_en),
      .rd_col     (lat_rd_col),
      .wr_en      (lat_wr_en),
      .wr_col     (lat_wr_col),
      .done       (done)
   );

   ssr_fold #(.NB(NB), .NLAT(NLAT)) u_fold (
      .planes (lat_rd_data),
      .inh    (inh)
   );

   ssr_merge #(.NB(NB), .NLAT(NLAT)) u_merge (
      .user   (cache_q),
      .inh    (lat_rd_data[INH_PLANE*NB +: NB]),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cache_q <= '0;
      else if (lat_rd_en && st == ST_RES_GO) cache_q <= cache_data;
   end

   for (genvar p = 0; p < NLAT; p++) begin : g_fold_place
      if (p == INH_PLANE) begin : g_inh
         assign fold_data[p*NB +: NB] = inh;
      end else begin : g_free
         assign fold_data[p*NB +: NB] = '0;
      end
   end

   assign rebuilding  = (st == ST_RES_GO);
   assign lat_wr_data = rebuilding ? merged : fold_data;
   assign lat_wr_mask = rebuilding ? {NLAT{1'b1}} : NLAT'(1) << INH_PLANE;

   assign busy       = (st == ST_SUSP_GO) || rebuilding;
   assign rd_grant   = (st == ST_PARKED);
   assign pgm_active = (st == ST_PGM);

   a_r4_inhibit_plane_only: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_wr_en && !rebuilding) |-> ($onehot0(lat_wr_mask) && lat_wr_mask[INH_PLANE]));
   a_r7_full_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_wr_en && rebuilding) |-> (lat_wr_mask == {NLAT{1'b1}}));
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r1_writes_follow_reads: assert property (@(posedge clk) disable iff (!rst_n)
      lat_wr_en |-> $past(lat_rd_en));
   a_r6_grant_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_grant && (busy || pgm_active)));
endmodule

// File: tb/suspend_latch_mgr_bench.sv
module suspend_latch_mgr_bench;
   localparam int NB = 8, NCOL = 16, NLAT = 4, INH = 0, AW = 4, DW = NB*NLAT;

   logic clk = 0, rst_n = 0;
   logic cmd_start = 0, cmd_finish = 0, cmd_suspend = 0, cmd_resume = 0;
   logic cache_vld = 0;
   logic [DW-1:0] cache_data = '0;
   logic lat_rd_en, lat_wr_en, busy, rd_grant, pgm_active, done;
   logic [AW-1:0] lat_rd_col, lat_wr_col;
   logic [NLAT-1:0] lat_wr_mask;
   logic [DW-1:0] lat_wr_data, rd_q;

   logic [NB-1:0] mem [NLAT][NCOL];
   logic [NB-1:0] usr [NLAT][NCOL];
   logic [NB-1:0] pre [NLAT][NCOL];
   logic tb_we = 0;
   int tb_p = 0, tb_c = 0;
   logic [NB-1:0] tb_d = '0;
   int total = 0, bad = 0, n_done = 0;

   always #10 clk = ~clk;

   suspend_latch_mgr #(.NB(NB), .NCOL(NCOL), .NLAT(NLAT), .INH_PLANE(INH)) u_suspend_latch_mgr (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_finish(cmd_finish),
      .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cache_vld(cache_vld),
      .cache_data(cache_data), .lat_rd_en(lat_rd_en), .lat_rd_col(lat_rd_col),
      .lat_rd_data(rd_q), .lat_wr_en(lat_wr_en), .lat_wr_col(lat_wr_col),
      .lat_wr_mask(lat_wr_mask), .lat_wr_data(lat_wr_data), .busy(busy),
      .rd_grant(rd_grant), .pgm_active(pgm_active), .done(done));

   always @(posedge clk) begin
      if (lat_rd_en) for (int p = 0; p < NLAT; p++) rd_q[p*NB +: NB] <= mem[p][lat_rd_col];
      if (lat_wr_en) for (int p = 0; p < NLAT; p++)
         if (lat_wr_mask[p]) mem[p][lat_wr_col] <= lat_wr_data[p*NB +: NB];
      if (tb_we) mem[tb_p][tb_c] <= tb_d;
      if (rst_n && done) n_done <= n_done + 1;
   end

   task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NB-1:0] exp_inh(int c);
      logic [NB-1:0] r = '1;
      for (int p = 0; p < NLAT; p++) r &= pre[p][c];
      return r;
   endfunction

   function automatic logic [DW-1:0] pack_usr(int c);
      logic [DW-1:0] r;
      for (int p = 0; p < NLAT; p++) r[p*NB +: NB] = usr[p][c];
      return r;
   endfunction

   task automatic poke(int p, int c, logic [NB-1:0] d);
      @(negedge clk); tb_we = 1; tb_p = p; tb_c = c; tb_d = d;
      @(negedge clk); tb_we = 0;
   endtask

   task automatic pulse(int which);
      @(negedge clk);
      case (which)
         0: cmd_start = 1;
         1: cmd_finish = 1;
         2: cmd_suspend = 1;
         default: cmd_resume = 1;
      endcase
      @(negedge clk);
      cmd_start = 0; cmd_finish = 0; cmd_suspend = 0; cmd_resume = 0;
   endtask

   task automatic load_page(int variant);
      for (int c = 0; c < NCOL; c++) begin
         logic [NB-1:0] im = NB'($urandom);
         for (int p = 0; p < NLAT; p++) usr[p][c] = NB'($urandom);
         if (c == 0) im = '1;
         if (c == 1) begin im = '0; for (int p = 0; p < NLAT; p++) usr[p][c] = '0; end
         if (c == 2) begin im = '0; for (int p = 0; p < NLAT; p++) usr[p][c] = '1; end
         if (variant == 1 && c == NCOL-1) im = 8'h81;
         for (int p = 0; p < NLAT; p++) begin
            pre[p][c] = usr[p][c] | im;
            poke(p, c, pre[p][c]);
         end
      end
   endtask

   task automatic run_cycle(int gappy);
      int n, d0, c;
      d0 = n_done;
      pulse(2);
      check(busy == 1, "R3 busy after suspend", busy, 1);
      n = 1;
      while (!done && n < 200) begin @(negedge clk); n++; end
      check(n == NCOL+1, "R5 suspend done latency", n, NCOL+1);
      @(negedge clk);
      check(rd_grant == 1 && busy == 0, "R6 parked grant", {rd_grant, busy}, 2'b10);
      check(n_done == d0 + 1, "R5 single done pulse", n_done - d0, 1);
      for (int cc = 0; cc < NCOL; cc++) begin
         check(mem[INH][cc] == exp_inh(cc), "R4 inhibit fold", mem[INH][cc], exp_inh(cc));
         for (int p = 0; p < NLAT; p++)
            if (p != INH) check(mem[p][cc] == pre[p][cc], "R4 free plane untouched", mem[p][cc], pre[p][cc]);
      end
      for (int cc = 0; cc < NCOL; cc++)
         for (int p = 0; p < NLAT; p++) if (p != INH) poke(p, cc, NB'($urandom));
      pulse(2);
      check(busy == 0 && rd_grant == 1, "R3 suspend ignored when parked", {busy, rd_grant}, 2'b01);
      @(negedge clk); cmd_resume = 1;
      @(negedge clk); cmd_resume = 0;
      check(busy == 1, "R7 busy after resume", busy, 1);
      c = 0;
      while (c < NCOL) begin
         logic v = gappy ? (($urandom % 3) != 0) : 1'b1;
         cache_vld = v; cache_data = pack_usr(c);
         @(negedge clk);
         if (v) c++;
      end
      cache_vld = 0;
      check(done == 1, "R8 done after last rebuild", done, 1);
      @(negedge clk);
      check(pgm_active == 1 && busy == 0, "R8 back to program", {pgm_active, busy}, 2'b10);
      check(n_done == d0 + 2, "R8 single done pulse", n_done - d0, 2);
      for (int cc = 0; cc < NCOL; cc++)
         for (int p = 0; p < NLAT; p++) begin
            logic [NB-1:0] e = usr[p][cc] | exp_inh(cc);
            check(mem[p][cc] == e, "R7 rebuild OR", mem[p][cc], e);
         end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(busy == 0 && rd_grant == 0 && pgm_active == 0 && done == 0 && lat_rd_en == 0 && lat_wr_en == 0,
            "R1 reset state", {busy, rd_grant, pgm_active, done}, 0);
      rst_n = 1;
      pulse(2);
      check(busy == 0 && pgm_active == 0, "R3 suspend ignored when idle", {busy, pgm_active}, 0);
      pulse(3);
      check(busy == 0 && rd_grant == 0, "R9 resume ignored when idle", {busy, rd_grant}, 0);
      load_page(0);
      pulse(0);
      check(pgm_active == 1, "R2 start enters program", pgm_active, 1);
      pulse(3);
      check(busy == 0 && pgm_active == 1, "R9 resume ignored in program", {busy, pgm_active}, 2'b01);
      run_cycle(0);
      load_page(1);
      run_cycle(1);
      pulse(1);
      check(pgm_active == 0 && busy == 0, "R2 finish returns idle", {pgm_active, busy}, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule